// File: doc/BRIEF.md
# Pad Function Mux and GPIO Controller

This block decides, for every pad of one power domain, whether a peripheral function or the general-purpose I/O logic drives it, and which pull bias the pad cell receives. Software programs it through a small word-addressed register bus. One register holds an enable bit per function group. Further registers hold the pull enable, the pull direction, the GPIO direction, the GPIO output value and the synchronised pad input levels.

Pads are organised in banks. Each bank occupies a contiguous span of bits inside shared registers, starting at a configurable bit offset. A pad belongs to a function group through a build-time membership mask. When no enabled group covers a pad, the pad is under GPIO control. A build parameter places the pull-enable bits in the upper half of the pull-direction register, so only one pull register exists.

Top module: `pad_mux_ctrl`

## Requirements
- R1: Byte address = register index × 4. The indices are: 0 function enables, 1 pull enable, 2 pull direction, 3 GPIO direction, 4 GPIO output, 5 input levels. A byte address with nonzero low two bits, or with any other index, reads 0 and ignores writes. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational.
- R2: After reset every register is 0. Every pad is a GPIO output driving low, with no pull applied.
- R3: The bit of pad p in bank b is BANK_BIT[b] + p − BANK_FIRST[b]. By default, pads 0–5 use bits 0–5 and pads 6–11 use bits 8–13. Unused bits read 0 and are ignored on write.
- R4: Bit g of register 0 enables group g. By default the members are: group 0 pads {0,1}, group 1 pads {1,2,3}, group 2 pads {8..11}, group 3 pads {0,9}. An owned pad takes `pad_oe`/`pad_do` from `fn_oe[g]`/`fn_do[g]`.
- R5: A pad that no enabled group covers is in GPIO mode. Direction bit 1 makes it an input (`pad_oe`=0). Direction bit 0 makes it drive the output register bit on `pad_do`.
- R6: When several enabled groups cover a pad, the lowest-numbered group owns it.
- R7: Pull-enable bit 0 gives no bias. With pull enable at 1, a pull-direction bit of 1 raises `pad_pu` and 0 raises `pad_pd`.
- R8: With PULL_SHARED=1, pull-enable bits sit at bit position + 16 in register 2, and index 1 is unmapped.
- R9: Register 5 is read-only. It shows `pad_in` two clock edges after the pad changes.
- R10: Configuration changes only on a write. Clearing a competing group's bit hands a pad directly to a still-enabled group, with no intervening GPIO-mode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| fn_oe | input | NUM_GROUPS | Output enable from each function group |
| fn_do | input | NUM_GROUPS | Output value from each function group |
| pad_in | input | NUM_PADS | Asynchronous pad levels |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_do | output | NUM_PADS | Pad output value |
| pad_pu | output | NUM_PADS | Pull-up request |
| pad_pd | output | NUM_PADS | Pull-down request |

## Verification
A corrupted configuration bit appears on the pad outputs in the cycle after the write that stored it. It also appears on readback of that register at the same time. A wrong bank offset shows up as a pad that follows the neighbouring bit. A wrong priority shows up as an overlapped pad driven by the higher-numbered group. A fault in the input synchroniser appears as register 5 showing a new level one edge early or late. A fault in the shared pull layout appears as the wrong pull on a pad of the second instance.

// File: rtl/pad_mux_ctrl.sv
module pad_mux_ctrl #(
  parameter int NUM_PADS = 12,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W = 8,
  parameter bit PULL_SHARED = 1'b0,
  parameter int PEN_SHIFT = 16,
  parameter logic [NUM_BANKS*8-1:0] BANK_FIRST = {8'd6, 8'd0},
  parameter logic [NUM_BANKS*8-1:0] BANK_BIT = {8'd8, 8'd0},
  parameter logic [NUM_GROUPS*NUM_PADS-1:0] GROUP_PADS = {12'h201, 12'hF00, 12'h00E, 12'h003}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_GROUPS-1:0] fn_oe,
  input  logic [NUM_GROUPS-1:0] fn_do,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_oe,
  output logic [NUM_PADS-1:0]   pad_do,
  output logic [NUM_PADS-1:0]   pad_pu,
  output logic [NUM_PADS-1:0]   pad_pd
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] IDX_MUX  = 0;
  localparam logic [IW-1:0] IDX_PEN  = 1;
  localparam logic [IW-1:0] IDX_PDIR = 2;
  localparam logic [IW-1:0] IDX_DIR  = 3;
  localparam logic [IW-1:0] IDX_OUT  = 4;
  localparam logic [IW-1:0] IDX_IN   = 5;
  localparam int EN_OFS = PULL_SHARED ? PEN_SHIFT : 0;

  function automatic int pad_bit(int p);
    pad_bit = 0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (p >= int'(BANK_FIRST[b*8 +: 8]))
        pad_bit = int'(BANK_BIT[b*8 +: 8]) + p - int'(BANK_FIRST[b*8 +: 8]);
  endfunction

  logic [NUM_GROUPS-1:0] mux_q;
  logic [NUM_PADS-1:0] pen_q, pdir_q, dir_q, out_q, in_s1, in_s2;
  logic [IW-1:0] idx;
  logic aligned, wr_mux, wr_pen, wr_pdir, wr_dir, wr_out;
  logic unused_bits;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_mux  = bus_wr && aligned && idx == IDX_MUX;
  assign wr_pdir = bus_wr && aligned && idx == IDX_PDIR;
  assign wr_pen  = PULL_SHARED ? wr_pdir : (bus_wr && aligned && idx == IDX_PEN);
  assign wr_dir  = bus_wr && aligned && idx == IDX_DIR;
  assign wr_out  = bus_wr && aligned && idx == IDX_OUT;
  assign unused_bits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q  <= '0;
      pen_q  <= '0;
      pdir_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      in_s1  <= '0;
      in_s2  <= '0;
    end else begin
      in_s1 <= pad_in;
      in_s2 <= in_s1;
      if (wr_mux) mux_q <= bus_wdata[NUM_GROUPS-1:0];
      for (int p = 0; p < NUM_PADS; p++) begin
        if (wr_pen)  pen_q[p]  <= bus_wdata[pad_bit(p) + EN_OFS];
        if (wr_pdir) pdir_q[p] <= bus_wdata[pad_bit(p)];
        if (wr_dir)  dir_q[p]  <= bus_wdata[pad_bit(p)];
        if (wr_out)  out_q[p]  <= bus_wdata[pad_bit(p)];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_MUX: bus_rdata[NUM_GROUPS-1:0] = mux_q;
        IDX_PEN: if (!PULL_SHARED)
                   for (int p = 0; p < NUM_PADS; p++) bus_rdata[pad_bit(p)] = pen_q[p];
        IDX_PDIR: for (int p = 0; p < NUM_PADS; p++) begin
                    bus_rdata[pad_bit(p)] = pdir_q[p];
                    if (PULL_SHARED) bus_rdata[pad_bit(p) + EN_OFS] = pen_q[p];
                  end
        IDX_DIR: for (int p = 0; p < NUM_PADS; p++) bus_rdata[pad_bit(p)] = dir_q[p];
        IDX_OUT: for (int p = 0; p < NUM_PADS; p++) bus_rdata[pad_bit(p)] = out_q[p];
        IDX_IN:  for (int p = 0; p < NUM_PADS; p++) bus_rdata[pad_bit(p)] = in_s2[p];
        default: ;
      endcase
    end
  end

  // Descending scan: the lowest enabled group covering a pad is applied last.
  always_comb begin
    for (int p = 0; p < NUM_PADS; p++) begin
      pad_oe[p] = ~dir_q[p];
      pad_do[p] = out_q[p];
      for (int g = NUM_GROUPS - 1; g >= 0; g--)
        if (mux_q[g] && GROUP_PADS[g*NUM_PADS + p]) begin
          pad_oe[p] = fn_oe[g];
          pad_do[p] = fn_do[g];
        end
    end
  end

  assign pad_pu = pen_q & pdir_q;
  assign pad_pd = pen_q & ~pdir_q;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assert_reset_clear_R2: assert property (@(posedge clk)
    $past(!rst_n) |-> ({mux_q, pen_q, pdir_q, dir_q, out_q} == '0));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({mux_q, pen_q, pdir_q, dir_q, out_q}));

  assert_gpio_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mux && bus_wdata[NUM_GROUPS-1:0] == '0) |=> (pad_oe == ~dir_q && pad_do == out_q));

  assert_pull_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu | pad_pd) & ~pen_q) == '0);

  assert_in_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (in_s2 == $past(pad_in, 2)));
endmodule

// File: tb/pad_mux_ctrl_tb.sv
module pad_mux_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] fn_oe = '0, fn_do = '0;
  logic [11:0] pad_in = '0;
  logic [31:0] rdata_n, rdata_s;
  logic [11:0] oe_n, do_n, pu_n, pd_n, oe_s, do_s, pu_s, pd_s;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  pad_mux_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .fn_oe(fn_oe), .fn_do(fn_do),
    .pad_in(pad_in), .pad_oe(oe_n), .pad_do(do_n), .pad_pu(pu_n), .pad_pd(pd_n));

  pad_mux_ctrl #(.PULL_SHARED(1'b1)) u_dut_sh (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .fn_oe(fn_oe), .fn_do(fn_do),
    .pad_in(pad_in), .pad_oe(oe_s), .pad_do(do_s), .pad_pu(pu_s), .pad_pd(pd_s));

  localparam logic [11:0] GP [4] = '{12'h003, 12'h00E, 12'hF00, 12'h201};

  logic [3:0] m_mux = '0;
  logic [11:0] m_pen_n = '0, m_pen_s = '0, m_pdir = '0, m_dir = '0, m_out = '0, m_in = '0;

  function automatic int bitpos(int p);
    return (p < 6) ? p : p + 2;
  endfunction

  function automatic logic [31:0] spread(logic [11:0] v);
    logic [31:0] r = '0;
    for (int p = 0; p < 12; p++) r[bitpos(p)] = v[p];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a, bit shared);
    if (a[1:0] != 2'b00) return '0;
    case (a[7:2])
      6'd0: return {28'd0, m_mux};
      6'd1: return shared ? '0 : spread(m_pen_n);
      6'd2: return spread(m_pdir) | (shared ? (spread(m_pen_s) << 16) : '0);
      6'd3: return spread(m_dir);
      6'd4: return spread(m_out);
      6'd5: return spread(m_in);
      default: return '0;
    endcase
  endfunction

  function automatic logic [23:0] exp_drive();
    logic [11:0] oe, dv;
    for (int p = 0; p < 12; p++) begin
      bit hit = 0;
      oe[p] = ~m_dir[p];
      dv[p] = m_out[p];
      for (int g = 0; g < 4; g++)
        if (!hit && m_mux[g] && GP[g][p]) begin
          hit = 1;
          oe[p] = fn_oe[g];
          dv[p] = fn_do[g];
        end
    end
    return {oe, dv};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    if (a[1:0] != 2'b00) return;
    for (int p = 0; p < 12; p++) begin
      case (a[7:2])
        6'd1: m_pen_n[p] = d[bitpos(p)];
        6'd2: begin m_pdir[p] = d[bitpos(p)]; m_pen_s[p] = d[bitpos(p) + 16]; end
        6'd3: m_dir[p] = d[bitpos(p)];
        6'd4: m_out[p] = d[bitpos(p)];
        default: ;
      endcase
    end
    if (a[7:2] == 6'd0) m_mux = d[3:0];
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [7:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic check_pads(string req);
    logic [23:0] e;
    #1;
    e = exp_drive();
    chk({req, " oe"}, {20'd0, oe_n}, {20'd0, e[23:12]});
    chk({req, " do"}, {20'd0, do_n}, {20'd0, e[11:0]});
    chk({req, " pull"}, {8'd0, pu_n, pd_n}, {8'd0, m_pen_n & m_pdir, m_pen_n & ~m_pdir});
    chk({req, " shared pull R8"}, {8'd0, pu_s, pd_s}, {8'd0, m_pen_s & m_pdir, m_pen_s & ~m_pdir});
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    check_pads("R2 reset");
    chk("R2 oe all out", {20'd0, oe_n}, 32'hFFF);
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4));
      chk("R2 reg zero", rdata_n, 32'd0);
    end

    // R3: bank bit mapping
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C); chk("R3 dir span", rdata_n, 32'h0000_3F3F);
    check_pads("R3 all inputs");
    wr(8'h10, 32'h0000_0100);
    rd(8'h10); chk("R3 pad6 out bit8", rdata_n, 32'h100);
    wr(8'h0C, 32'h0);
    #1; chk("R5 pad6 drives high", {31'd0, do_n[6]}, 32'd1);

    // R1: misaligned and unmapped
    wr(8'h01, 32'hF);
    rd(8'h00); chk("R1 misaligned write ignored", rdata_n, 32'd0);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C); chk("R1 unmapped read zero", rdata_n, 32'd0);

    // R6 priority, R4 ownership
    fn_oe = 4'b0001; fn_do = 4'b0010;
    wr(8'h00, 32'h3);
    #1;
    chk("R6 pad1 group0 oe", {31'd0, oe_n[1]}, 32'd1);
    chk("R6 pad1 group0 do", {31'd0, do_n[1]}, 32'd0);
    chk("R4 pad2 group1", {30'd0, oe_n[2], do_n[2]}, 32'b01);
    check_pads("R4 overlap");

    // R10: handover without GPIO cycle
    wr(8'h0C, 32'h2);
    fn_oe = 4'b0011; fn_do = 4'b0001;
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h2; bus_wr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 pad1 stays driven", {31'd0, oe_n[1]}, 32'd1);
      bus_wr = 1'b0;
    end
    model_write(8'h00, 32'h2);
    chk("R10 pad1 now group1", {31'd0, do_n[1]}, 32'd0);

    // R7 pulls
    wr(8'h04, 32'h0000_0103);
    wr(8'h08, 32'h0000_0001);
    #1;
    chk("R7 pad0 pull up", {30'd0, pu_n[0], pd_n[0]}, 32'b10);
    chk("R7 pad1 pull down", {30'd0, pu_n[1], pd_n[1]}, 32'b01);
    chk("R7 pad2 no pull", {30'd0, pu_n[2], pd_n[2]}, 32'b00);

    // R8 shared layout
    wr(8'h08, 32'h0101_0001);
    #1;
    chk("R8 shared pad0 up", {30'd0, pu_s[0], pd_s[0]}, 32'b10);
    chk("R8 shared pad6 down", {30'd0, pu_s[6], pd_s[6]}, 32'b01);
    rd(8'h04); chk("R8 index1 unmapped", rdata_s, 32'd0);
    rd(8'h08); chk("R8 readback", rdata_s, 32'h0101_0001);

    // R9 synchroniser and read-only input
    @(negedge clk); pad_in = 12'hA5C; bus_addr = 8'h14;
    @(negedge clk); #1;
    chk("R9 one edge old", rdata_n, spread(12'h000));
    @(negedge clk); #1;
    chk("R9 two edges new", rdata_n, spread(12'hA5C));
    m_in = 12'hA5C;
    wr(8'h14, 32'h0);
    rd(8'h14); chk("R9 write ignored", rdata_n, spread(12'hA5C));

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a;
      logic [31:0] d;
      int ix;
      ix = int'($urandom % 8);
      a = 8'(ix * 4);
      if ($urandom % 8 == 0) a = a + 8'(1 + $urandom % 3);
      d = $urandom;
      @(negedge clk);
      pad_in = 12'($urandom);
      fn_oe = 4'($urandom); fn_do = 4'($urandom);
      wr(a, d);
      @(negedge clk);
      m_in = pad_in;
      check_pads("R4 R5 R6 R7 random");
      rd(a);
      chk("R1 R3 random readback", rdata_n, exp_read(a, 1'b0));
      chk("R8 random readback", rdata_s, exp_read(a, 1'b1));
      rd(8'h14);
      chk("R9 random input", rdata_n, exp_read(8'h14, 1'b0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule